// File: doc/BRIEF.md
# Programmable Parallel Memory-Bus Master

This block takes one read or write request at a time from an internal request port. It plays the request out on an external parallel bus as a timed sequence of strobes. The bus can serve NOR flash, small FPGAs or UART-like peripherals. A configuration port sets three things: the length of every phase of the access, the polarity of each control line, and two bus options. The first option shares the data lines between address and data. The second chooses a 16-bit or 32-bit data bus. A separate option chooses whether the ready input leads the read data by one cycle or arrives with it. The block drives a single chip-select output and has no chip-select decoding. It latches the address (28 bits, a 256 MB window), so every access inside that window uses the same select line.

Each timing field is stored as a programmed value `n`, and the phase it controls lasts `n+1` clock cycles. The block is a state machine with these states: IDLE, SETUP, ADDR, MUXA, WPULSE, RPULSE, RWAIT, RDATA, HOLD and DONE. The transitions are:
- IDLE→SETUP when a request is accepted.
- SETUP→ADDR when the setup count expires.
- ADDR→MUXA, or straight to WPULSE or RPULSE when the shared-line mode is off.
- MUXA→WPULSE or RPULSE.
- WPULSE→HOLD.
- RPULSE→RWAIT.
- RWAIT→HOLD when ready arrives (normal mode) or the wait count expires.
- RWAIT→RDATA when ready arrives in early-ready mode.
- RDATA→HOLD.
- HOLD→DONE.
- DONE→IDLE.

The bus data lines are provided as separate out, in and lane-enable ports, so that the tristate pads can stay outside the block.

Top module: `pbus_master`

## Requirements
- R1: After reset, `req_busy` and `req_done` are 0 and `bus_dq_oe` is 0. Every control line is at its inactive level; all lines default to active-low, so the pins read 1. The reset timing values are: setup 4, address-valid 1, muxed address 1, write pulse 1, hold 1, read pulse 1, ready wait 3. Shared-line mode, 32-bit width and early ready are all off.
- R2: Every timing field `n` produces a phase of exactly `n+1` cycles. Setup, address-valid, muxed address, write pulse and hold are 4-bit fields. Read pulse and ready wait are 8-bit fields.
- R3: After a request is accepted, `req_busy` is high with chip select inactive for setup+1 cycles before chip select becomes active.
- R4: The address-valid strobe is active for address-valid+1 cycles, during which chip select is already active.
- R5: In shared-line mode, the address (zero-extended) is driven on the data lines for address-valid+1 + muxed+1 cycles. After that the lines are released on a read, or carry write data on a write. With the mode off, the address never appears on the data lines.
- R6: A write drives the write strobe for write+1 cycles. The data lines carry the write data throughout the write pulse and the hold phase, for write+1 + hold+1 cycles.
- R7: On a read, the read strobe stays active for read+1 cycles and then waits for ready. With normal ready, a ready seen in a wait cycle captures the data lines in that same cycle and ends the wait. With ready always present, the read strobe is active for read+2 cycles.
- R8: With early ready, a ready seen in a wait cycle adds one more read-strobe cycle, and the data lines are captured in that added cycle. With ready always present, the read strobe is active for read+3 cycles.
- R9: If ready never arrives, the wait ends after wait+1 cycles and the data lines are captured in the last wait cycle. The read strobe is then active for read+wait+2 cycles.
- R10: Chip select stays active for hold+1 cycles after the write or read strobe is released. Chip select is active for address-valid+1 + (muxed+1 in shared mode) + strobe cycles + hold+1 cycles in total.
- R11: The chip-select, address-valid, strobe (write and read together) and ready lines each have their own polarity bit. A polarity bit of 1 makes that line active-high, and idle levels follow the polarity.
- R12: In 16-bit mode, only lane enable bit 0 (data bits 15:0) is ever driven, and read data bits 31:16 return 0. In 32-bit mode, both lane enable bits switch together and all 32 bits are captured.
- R13: `req_busy` stays high from the accepted request until the cycle after the single `req_done` pulse. A request held valid, or a request whose address changes, during an access starts nothing new and does not alter `bus_addr`.
- R14: A configuration written while an access is in progress does not alter that access. It applies from the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Loads all cfg_* fields into the pending configuration |
| cfg_ce_w | input | 4 | Setup length before chip select (n+1 cycles) |
| cfg_adv_w | input | 4 | Address-valid strobe length |
| cfg_mux_w | input | 4 | Extra cycles the address stays on the data lines |
| cfg_we_w | input | 4 | Write pulse length |
| cfg_hold_w | input | 4 | Chip-select hold after the strobe |
| cfg_oe_w | input | 8 | Minimum read pulse length |
| cfg_wait_w | input | 8 | Ready wait limit |
| cfg_mux_en | input | 1 | Address and data share the data lines |
| cfg_wide | input | 1 | 1 = 32-bit bus, 0 = 16-bit bus |
| cfg_rdy_early | input | 1 | Ready leads data by one cycle |
| cfg_cs_hi | input | 1 | Chip select active-high |
| cfg_adv_hi | input | 1 | Address-valid active-high |
| cfg_strb_hi | input | 1 | Write and read strobes active-high |
| cfg_rdy_hi | input | 1 | Ready input active-high |
| req_valid | input | 1 | Access request, accepted in IDLE |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Access address |
| req_wdata | input | 32 | Write data |
| req_busy | output | 1 | Access in progress |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Captured read data |
| bus_cs | output | 1 | Chip select pin |
| bus_adv | output | 1 | Address-valid pin |
| bus_we | output | 1 | Write strobe pin |
| bus_oe | output | 1 | Read strobe pin |
| bus_addr | output | 28 | Latched address |
| bus_dq_out | output | 32 | Data lines, outgoing value |
| bus_dq_oe | output | 2 | Lane drive enables (bit 0 low half, bit 1 high half) |
| bus_dq_in | input | 32 | Data lines, incoming value |
| bus_rdy | input | 1 | Ready pin |

## Verification
A wrong state or a miscounted phase shows up at the pins as a strobe that lasts one cycle too long or too short. It also shows as a chip select that releases early, or as data lines that carry the address or data for the wrong number of cycles. The bench therefore counts the active cycles of every line during each access and compares the totals when `req_done` arises. This means a fault is reported at the end of the access it corrupts. A bad capture point or a wrong lane mask appears in `req_rdata` in that same done cycle. A configuration leaking into an access in progress changes that access's counts and is caught when it completes.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    localparam int SHORT_W = 4;
    localparam int LONG_W  = 8;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SETUP, ST_ADDR, ST_MUXA, ST_WPULSE,
        ST_RPULSE, ST_RWAIT, ST_RDATA, ST_HOLD, ST_DONE
    } pbus_state_e;

    typedef struct packed {
        logic [SHORT_W-1:0] ce_w;
        logic [SHORT_W-1:0] adv_w;
        logic [SHORT_W-1:0] mux_w;
        logic [SHORT_W-1:0] we_w;
        logic [SHORT_W-1:0] hold_w;
        logic [LONG_W-1:0]  oe_w;
        logic [LONG_W-1:0]  wait_w;
        logic               mux_en;
        logic               wide;
        logic               rdy_early;
        logic               cs_hi;
        logic               adv_hi;
        logic               strb_hi;
        logic               rdy_hi;
    } pbus_cfg_t;

    localparam pbus_cfg_t CFG_RESET = '{
        ce_w: 4'd4, adv_w: 4'd1, mux_w: 4'd1, we_w: 4'd1, hold_w: 4'd1,
        oe_w: 8'd1, wait_w: 8'd3,
        mux_en: 1'b0, wide: 1'b0, rdy_early: 1'b0,
        cs_hi: 1'b0, adv_hi: 1'b0, strb_hi: 1'b0, rdy_hi: 1'b0
    };
endpackage

// File: rtl/pbus_cfg.sv
module pbus_cfg
    import pbus_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  pbus_cfg_t wr_cfg,
    input  logic      busy,
    output pbus_cfg_t act
);
    pbus_cfg_t pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= CFG_RESET;
            act  <= CFG_RESET;
        end else begin
            if (wr) pend <= wr_cfg;
            if (!busy) act <= pend;
        end
    end

    // R14: the configuration in use is frozen for the whole access
    p_cfg_frozen_r14: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(act));
endmodule

// File: rtl/pbus_fsm.sv
module pbus_fsm
    import pbus_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SHORT_W-1:0] ce_w,
    input  logic [SHORT_W-1:0] adv_w,
    input  logic [SHORT_W-1:0] mux_w,
    input  logic [SHORT_W-1:0] we_w,
    input  logic [SHORT_W-1:0] hold_w,
    input  logic [LONG_W-1:0]  oe_w,
    input  logic [LONG_W-1:0]  wait_w,
    input  logic               mux_en,
    input  logic               wide,
    input  logic               rdy_early,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic               rdy_act,
    input  logic [DATA_W-1:0]  dq_in,
    output logic               busy,
    output logic               done,
    output logic [DATA_W-1:0]  rdata,
    output logic [ADDR_W-1:0]  lat_addr,
    output logic [DATA_W-1:0]  lat_wdata,
    output logic               cs_l,
    output logic               adv_l,
    output logic               we_l,
    output logic               oe_l,
    output logic               drive_addr,
    output logic               drive_data
);
    localparam int LANE_W = DATA_W / 2;

    pbus_state_e       st, st_nx;
    logic [LONG_W-1:0] cnt, lim;
    logic              phase_end, wr_q, cap;

    // phase limit for the current state (length = limit + 1)
    always_comb begin
        unique case (st)
            ST_SETUP:  lim = LONG_W'(ce_w);
            ST_ADDR:   lim = LONG_W'(adv_w);
            ST_MUXA:   lim = LONG_W'(mux_w);
            ST_WPULSE: lim = LONG_W'(we_w);
            ST_RPULSE: lim = oe_w;
            ST_RWAIT:  lim = wait_w;
            ST_HOLD:   lim = LONG_W'(hold_w);
            default:   lim = '0;
        endcase
    end

    assign phase_end = (cnt == lim);

    always_comb begin
        st_nx = st;
        cap   = 1'b0;
        unique case (st)
            ST_IDLE:   if (req_valid) st_nx = ST_SETUP;
            ST_SETUP:  if (phase_end) st_nx = ST_ADDR;
            ST_ADDR:   if (phase_end) st_nx = mux_en ? ST_MUXA
                                              : (wr_q ? ST_WPULSE : ST_RPULSE);
            ST_MUXA:   if (phase_end) st_nx = wr_q ? ST_WPULSE : ST_RPULSE;
            ST_WPULSE: if (phase_end) st_nx = ST_HOLD;
            ST_RPULSE: if (phase_end) st_nx = ST_RWAIT;
            ST_RWAIT: begin
                if (rdy_act && rdy_early) begin
                    st_nx = ST_RDATA;
                end else if (rdy_act || phase_end) begin
                    st_nx = ST_HOLD;
                    cap   = 1'b1;
                end
            end
            ST_RDATA: begin
                st_nx = ST_HOLD;
                cap   = 1'b1;
            end
            ST_HOLD:   if (phase_end) st_nx = ST_DONE;
            ST_DONE:   st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // state register and phase counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= (st_nx != st || st == ST_IDLE) ? '0 : cnt + 1'b1;
        end
    end

    // request latches and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q      <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            rdata     <= '0;
        end else begin
            if (st == ST_IDLE && req_valid) begin
                wr_q      <= req_write;
                lat_addr  <= req_addr;
                lat_wdata <= req_wdata;
            end
            if (cap) rdata <= wide ? dq_in : {{LANE_W{1'b0}}, dq_in[LANE_W-1:0]};
        end
    end

    // logical (active-high) outputs per state
    always_comb begin
        cs_l       = 1'b0;
        adv_l      = 1'b0;
        we_l       = 1'b0;
        oe_l       = 1'b0;
        drive_addr = 1'b0;
        drive_data = 1'b0;
        busy       = 1'b1;
        done       = 1'b0;
        unique case (st)
            ST_IDLE:   busy = 1'b0;
            ST_SETUP:  ;
            ST_ADDR: begin
                cs_l = 1'b1; adv_l = 1'b1; drive_addr = mux_en;
            end
            ST_MUXA: begin
                cs_l = 1'b1; drive_addr = 1'b1;
            end
            ST_WPULSE: begin
                cs_l = 1'b1; we_l = 1'b1; drive_data = 1'b1;
            end
            ST_RPULSE, ST_RWAIT, ST_RDATA: begin
                cs_l = 1'b1; oe_l = 1'b1;
            end
            ST_HOLD: begin
                cs_l = 1'b1; drive_data = wr_q;
            end
            ST_DONE:   done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    // R13: a done pulse is followed by an idle port
    p_done_then_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));
    // R13: address held for the whole access
    p_addr_latched_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(lat_addr));
    // R10: chip select still active when a strobe is released
    p_hold_after_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_l || oe_l) |-> cs_l);
    // R2: phase counter never passes its limit
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= lim));
    // R7: read data only changes after a wait or data cycle
    p_rdata_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> ($past(st) == ST_RWAIT || $past(st) == ST_RDATA));
endmodule

// File: rtl/pbus_pins.sv
module pbus_pins #(
    parameter int ADDR_W = 28,
    parameter int DATA_W = 32
) (
    input  logic              cs_l,
    input  logic              adv_l,
    input  logic              we_l,
    input  logic              oe_l,
    input  logic              drive_addr,
    input  logic              drive_data,
    input  logic [ADDR_W-1:0] lat_addr,
    input  logic [DATA_W-1:0] lat_wdata,
    input  logic              wide,
    input  logic              cs_hi,
    input  logic              adv_hi,
    input  logic              strb_hi,
    input  logic              rdy_hi,
    input  logic              bus_rdy,
    output logic              rdy_act,
    output logic              bus_cs,
    output logic              bus_adv,
    output logic              bus_we,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_dq_out,
    output logic [1:0]        bus_dq_oe
);
    localparam int LANE_W = DATA_W / 2;
    localparam int N_LINE = 4;

    logic [N_LINE-1:0] act_v, hi_v, pin_v;
    logic [DATA_W-1:0] val;
    logic              drive;

    assign act_v = {oe_l, we_l, adv_l, cs_l};
    assign hi_v  = {strb_hi, strb_hi, adv_hi, cs_hi};

    for (genvar i = 0; i < N_LINE; i++) begin : g_pol
        assign pin_v[i] = hi_v[i] ? act_v[i] : ~act_v[i];
    end

    assign bus_cs  = pin_v[0];
    assign bus_adv = pin_v[1];
    assign bus_we  = pin_v[2];
    assign bus_oe  = pin_v[3];
    assign rdy_act = rdy_hi ? bus_rdy : ~bus_rdy;

    assign drive      = drive_addr | drive_data;
    assign val        = drive_addr ? DATA_W'(lat_addr) : lat_wdata;
    assign bus_dq_out = wide ? val : {{LANE_W{1'b0}}, val[LANE_W-1:0]};
    assign bus_dq_oe  = {drive & wide, drive};
endmodule

// File: rtl/pbus_master.sv
module pbus_master
    import pbus_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [3:0]        cfg_ce_w,
    input  logic [3:0]        cfg_adv_w,
    input  logic [3:0]        cfg_mux_w,
    input  logic [3:0]        cfg_we_w,
    input  logic [3:0]        cfg_hold_w,
    input  logic [7:0]        cfg_oe_w,
    input  logic [7:0]        cfg_wait_w,
    input  logic              cfg_mux_en,
    input  logic              cfg_wide,
    input  logic              cfg_rdy_early,
    input  logic              cfg_cs_hi,
    input  logic              cfg_adv_hi,
    input  logic              cfg_strb_hi,
    input  logic              cfg_rdy_hi,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_busy,
    output logic              req_done,
    output logic [DATA_W-1:0] req_rdata,
    output logic              bus_cs,
    output logic              bus_adv,
    output logic              bus_we,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dq_out,
    output logic [1:0]        bus_dq_oe,
    input  logic [DATA_W-1:0] bus_dq_in,
    input  logic              bus_rdy
);
    pbus_cfg_t         wr_cfg, act;
    logic              rdy_act, cs_l, adv_l, we_l, oe_l, drive_addr, drive_data;
    logic [DATA_W-1:0] lat_wdata;

    assign wr_cfg = '{
        ce_w: cfg_ce_w, adv_w: cfg_adv_w, mux_w: cfg_mux_w, we_w: cfg_we_w,
        hold_w: cfg_hold_w, oe_w: cfg_oe_w, wait_w: cfg_wait_w,
        mux_en: cfg_mux_en, wide: cfg_wide, rdy_early: cfg_rdy_early,
        cs_hi: cfg_cs_hi, adv_hi: cfg_adv_hi, strb_hi: cfg_strb_hi,
        rdy_hi: cfg_rdy_hi
    };

    pbus_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .wr_cfg (wr_cfg),
        .busy   (req_busy),
        .act    (act)
    );

    pbus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_w       (act.ce_w),
        .adv_w      (act.adv_w),
        .mux_w      (act.mux_w),
        .we_w       (act.we_w),
        .hold_w     (act.hold_w),
        .oe_w       (act.oe_w),
        .wait_w     (act.wait_w),
        .mux_en     (act.mux_en),
        .wide       (act.wide),
        .rdy_early  (act.rdy_early),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rdy_act    (rdy_act),
        .dq_in      (bus_dq_in),
        .busy       (req_busy),
        .done       (req_done),
        .rdata      (req_rdata),
        .lat_addr   (bus_addr),
        .lat_wdata  (lat_wdata),
        .cs_l       (cs_l),
        .adv_l      (adv_l),
        .we_l       (we_l),
        .oe_l       (oe_l),
        .drive_addr (drive_addr),
        .drive_data (drive_data)
    );

    pbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .cs_l       (cs_l),
        .adv_l      (adv_l),
        .we_l       (we_l),
        .oe_l       (oe_l),
        .drive_addr (drive_addr),
        .drive_data (drive_data),
        .lat_addr   (bus_addr),
        .lat_wdata  (lat_wdata),
        .wide       (act.wide),
        .cs_hi      (act.cs_hi),
        .adv_hi     (act.adv_hi),
        .strb_hi    (act.strb_hi),
        .rdy_hi     (act.rdy_hi),
        .bus_rdy    (bus_rdy),
        .rdy_act    (rdy_act),
        .bus_cs     (bus_cs),
        .bus_adv    (bus_adv),
        .bus_we     (bus_we),
        .bus_oe     (bus_oe),
        .bus_dq_out (bus_dq_out),
        .bus_dq_oe  (bus_dq_oe)
    );
endmodule

// File: tb/pbus_master_test.sv
module pbus_master_test;
    import pbus_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_ce_w = '0, cfg_adv_w = '0, cfg_mux_w = '0, cfg_we_w = '0, cfg_hold_w = '0;
    logic [7:0]  cfg_oe_w = '0, cfg_wait_w = '0;
    logic        cfg_mux_en = 0, cfg_wide = 0, cfg_rdy_early = 0;
    logic        cfg_cs_hi = 0, cfg_adv_hi = 0, cfg_strb_hi = 0, cfg_rdy_hi = 0;
    logic        req_valid = 0, req_write = 0;
    logic [27:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_busy, req_done;
    logic [31:0] req_rdata;
    logic        bus_cs, bus_adv, bus_we, bus_oe;
    logic [27:0] bus_addr;
    logic [31:0] bus_dq_out;
    logic [1:0]  bus_dq_oe;
    logic [31:0] bus_dq_in = '0;
    logic        bus_rdy = 1'b1;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pbus_master uut (.*);

    typedef struct {
        bit          wr;
        logic [27:0] addr;
        logic [31:0] wdata;
        logic [31:0] rdata;
        bit          wide, cs_hi, adv_hi, strb_hi;
        int          setup, adv, cs, we, oe, addr_dq, data_dq;
        string       oe_tag;
    } exp_t;

    exp_t      q[$];
    pbus_cfg_t tb_cfg = CFG_RESET;

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic exp_t build(bit w, logic [27:0] a, logic [31:0] wd,
                                   logic [31:0] din, bit rlvl);
        exp_t e;
        int mx, rw;
        mx = tb_cfg.mux_en ? int'(tb_cfg.mux_w) + 1 : 0;
        rw = rlvl ? (tb_cfg.rdy_early ? 2 : 1) : int'(tb_cfg.wait_w) + 1;
        e.wr = w; e.addr = a; e.wdata = wd;
        e.rdata = tb_cfg.wide ? din : {16'h0, din[15:0]};
        e.wide = tb_cfg.wide; e.cs_hi = tb_cfg.cs_hi;
        e.adv_hi = tb_cfg.adv_hi; e.strb_hi = tb_cfg.strb_hi;
        e.setup = int'(tb_cfg.ce_w) + 1;
        e.adv = int'(tb_cfg.adv_w) + 1;
        e.we = w ? int'(tb_cfg.we_w) + 1 : 0;
        e.oe = w ? 0 : int'(tb_cfg.oe_w) + 1 + rw;
        e.cs = e.adv + mx + e.we + e.oe + int'(tb_cfg.hold_w) + 1;
        e.addr_dq = tb_cfg.mux_en ? e.adv + mx : 0;
        e.data_dq = w ? e.we + int'(tb_cfg.hold_w) + 1 : 0;
        e.oe_tag = !rlvl ? "R9" : (tb_cfg.rdy_early ? "R8" : "R7");
        return e;
    endfunction

    // monitor: counts active cycles of every line, compares at done
    int m_setup, m_adv, m_cs, m_we, m_oe, m_adq, m_ddq, m_lane, m_addr;
    always @(negedge clk) begin
        if (rst_n && req_done) begin
            if (q.size() == 0) begin
                chk("R13 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk("R3 setup cycles", m_setup, e.setup);
                chk("R4 address-valid cycles", m_adv, e.adv);
                chk("R2 R10 chip-select cycles", m_cs, e.cs);
                chk("R6 write strobe cycles", m_we, e.we);
                chk({e.oe_tag, " read strobe cycles"}, m_oe, e.oe);
                chk("R5 address on data lines", m_adq, e.addr_dq);
                chk("R6 data on data lines", m_ddq, e.data_dq);
                chk("R12 lane enables", m_lane, 0);
                chk("R13 bus address", m_addr, 0);
                if (!e.wr) chk({e.oe_tag, " R12 read data"}, req_rdata, e.rdata);
            end
            {m_setup, m_adv, m_cs, m_we, m_oe, m_adq, m_ddq, m_lane, m_addr} = '0;
        end else if (rst_n && req_busy && q.size() != 0) begin
            exp_t e;
            bit cs, dq0;
            logic [31:0] msk, av;
            e = q[0];
            cs = e.cs_hi ? bus_cs : !bus_cs;
            msk = e.wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
            av = {4'h0, e.addr};
            dq0 = bus_dq_oe[0];
            if (!cs) m_setup++;
            if (cs) m_cs++;
            if (e.adv_hi ? bus_adv : !bus_adv) m_adv++;
            if (e.strb_hi ? bus_we : !bus_we) m_we++;
            if (e.strb_hi ? bus_oe : !bus_oe) m_oe++;
            if (dq0 && ((bus_dq_out & msk) == (av & msk))) m_adq++;
            if (dq0 && ((bus_dq_out & msk) == (e.wdata & msk))) m_ddq++;
            if (bus_dq_oe[1] != (e.wide & dq0)) m_lane++;
            if (cs && bus_addr != e.addr) m_addr++;
        end
    end

    task automatic set_cfg(pbus_cfg_t c);
        @(negedge clk);
        {cfg_ce_w, cfg_adv_w, cfg_mux_w, cfg_we_w, cfg_hold_w} =
            {c.ce_w, c.adv_w, c.mux_w, c.we_w, c.hold_w};
        cfg_oe_w = c.oe_w; cfg_wait_w = c.wait_w;
        cfg_mux_en = c.mux_en; cfg_wide = c.wide; cfg_rdy_early = c.rdy_early;
        cfg_cs_hi = c.cs_hi; cfg_adv_hi = c.adv_hi;
        cfg_strb_hi = c.strb_hi; cfg_rdy_hi = c.rdy_hi;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        tb_cfg = c;
    endtask

    task automatic start_access(bit w, logic [27:0] a, logic [31:0] wd,
                                logic [31:0] din, bit rlvl);
        q.push_back(build(w, a, wd, din, rlvl));
        @(negedge clk);
        req_write = w; req_addr = a; req_wdata = wd;
        bus_dq_in = din;
        bus_rdy = tb_cfg.rdy_hi ? rlvl : !rlvl;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (req_busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic access(bit w, logic [27:0] a, logic [31:0] wd,
                          logic [31:0] din, bit rlvl);
        start_access(w, a, wd, din, rlvl);
        wait_idle();
    endtask

    initial begin
        #(20 * 150000);
        chk("watchdog expired", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        pbus_cfg_t c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset, active-low defaults
        chk("R1 busy", req_busy, 0);
        chk("R1 done", req_done, 0);
        chk("R1 lines", {bus_cs, bus_adv, bus_we, bus_oe}, 4'hF);
        chk("R1 lane enables", bus_dq_oe, 0);

        // reset timing values, 16-bit, separate lines
        access(1, 28'h0123456, 32'hA5A5_5A5A, 32'h0, 1);
        access(0, 28'h0ABCDEF, 32'h0, 32'hDEAD_BEEF, 1);

        // shared lines, 32-bit, odd timing
        c = CFG_RESET;
        c.ce_w = 0; c.adv_w = 0; c.mux_w = 2; c.we_w = 3; c.hold_w = 0;
        c.oe_w = 4; c.wait_w = 5; c.mux_en = 1; c.wide = 1;
        set_cfg(c);
        access(1, 28'h1234567, 32'hCAFE_F00D, 32'h0, 1);
        access(0, 28'h7654321, 32'h0, 32'h1357_9BDF, 1);
        // R9: ready never arrives
        access(0, 28'h0000400, 32'h0, 32'h2468_ACE0, 0);

        // R8: early ready
        c.rdy_early = 1; c.hold_w = 15;
        set_cfg(c);
        access(0, 28'h0F0F0F0, 32'h0, 32'h8765_4321, 1);
        access(0, 28'h0F0F0F4, 32'h0, 32'h1111_2222, 0);

        // R11: all lines active-high, 16-bit shared mode
        c.cs_hi = 1; c.adv_hi = 1; c.strb_hi = 1; c.rdy_hi = 1;
        c.wide = 0; c.rdy_early = 0; c.oe_w = 8'd200; c.ce_w = 4'd15;
        set_cfg(c);
        @(negedge clk);
        chk("R11 idle lines active-high", {bus_cs, bus_adv, bus_we, bus_oe}, 4'h0);
        access(0, 28'h0005A5A, 32'h0, 32'hFFFF_9999, 1);
        access(1, 28'h0003C3C, 32'h7777_1234, 32'h0, 1);

        // R14: configuration written mid-access
        c = CFG_RESET;
        set_cfg(c);
        start_access(1, 28'h0222222, 32'h0BAD_0BAD, 32'h0, 1);
        c.we_w = 9; c.adv_w = 6; c.hold_w = 3; c.wide = 1;
        repeat (2) @(negedge clk);
        set_cfg(c);
        wait_idle();
        access(1, 28'h0333333, 32'h5555_AAAA, 32'h0, 1);

        // R13: request held valid, address changes during access
        q.push_back(build(0, 28'h0444444, 32'h0, 32'h9ABC_DEF0, 1));
        @(negedge clk);
        req_write = 0; req_addr = 28'h0444444; bus_dq_in = 32'h9ABC_DEF0;
        bus_rdy = 1'b0; req_valid = 1'b1;
        repeat (3) @(negedge clk);
        req_addr = 28'h0999999;
        while (!req_done) @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        chk("R13 no extra access", req_busy, 0);
        chk("R13 queue drained", q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule